// File: doc/BRIEF.md
# Shared-Function Control Port

This block sits between an 8-pin pad ring and the logic that needs those pins. Each pin is either general-purpose I/O or carries a dedicated function: bus-control strobes for pins 7 to 2, and interrupt requests for pins 1 and 0. A function-select register picks the role of each pin. A direction register steers only the pins left as general-purpose I/O. The select register always wins over the direction register.

Pins 1 and 0 are input-only. When selected, pin 0 feeds the non-maskable interrupt input and pin 1 feeds the maskable one. Both stay readable through the data register in either role. A single enable turns on pull-ups for pins 7, 3, 2, 1 and 0. That enable register drops out of the register map while the chip runs in peripheral mode. The block does not generate the bus-control signals, does not implement the interrupt controller and does not contain the pads. It only selects and gates them.

Top module: `ctl_port`

## Requirements
- R1: After reset the data latch, direction, function-select and pull-up enable are all zero. pad_oe and pad_pu are 0, and irq_n and nmi_n are 1.
- R2: For a pin 7..2 whose select bit is 0, pad_oe follows its direction bit (1 = output) and pad_out carries the data latch bit.
- R3: For a pin 7..2 whose select bit is 1, pad_oe and pad_out follow fn_oe and fn_out, whatever its direction bit holds.
- R4: pad_oe[1:0] and pad_out[1:0] are always 0. Direction bits 1 and 0 read back as 0, and writes to them have no effect.
- R5: nmi_n equals pad_in[0] while select bit 0 is 1, and is 1 otherwise. irq_n equals pad_in[1] while select bit 1 is 1, and is 1 otherwise.
- R6: On a data-register read, bit i returns the data latch when pin i is a general-purpose output (i >= 2, select 0, direction 1). Otherwise it returns pad_in[i], including pins 1 and 0 while they feed interrupts.
- R7: When the pull-up enable (bit 0 at address 3) is 1, pad_pu is 8'h8F, which covers pins 7, 3, 2, 1 and 0. When the enable is 0, pad_pu is 8'h00.
- R8: While periph_mode is 1, address 3 reads 0 and writes to it are ignored. The pull-up state already held stays in effect.
- R9: The register map is: address 0 data, 1 direction, 2 function-select, 3 pull-up enable. Writes take effect at the rising clock edge when wr_en is 1. rdata is combinational on addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_mode | input | 1 | Peripheral mode; removes the pull-up register from the map |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| fn_out | input | 8 | Dedicated-function output levels |
| fn_oe | input | 8 | Dedicated-function output enables |
| pad_in | input | 8 | Levels seen at the pins |
| pad_out | output | 8 | Levels driven to the pins |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| irq_n | output | 1 | Maskable interrupt request, active low |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |

## Verification
Two functions can fall in the same cycle: interrupt routing on pins 1 and 0, and a data-register read of those same pins. The bench selects both interrupt functions and toggles pad_in[1:0] while address 0 is on the bus. In that same sample it requires that nmi_n and irq_n follow the pins and that rdata[1:0] returns the identical levels. The same pattern runs with the select bits cleared, where the interrupt outputs must stay idle while the read still tracks the pins.

// File: rtl/ctl_port.sv
module ctl_port #(
  parameter logic [7:0] PU_MASK = 8'h8F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       periph_mode,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] fn_out,
  input  logic [7:0] fn_oe,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_pu,
  output logic       irq_n,
  output logic       nmi_n
);

  logic [7:0] dat_q;
  logic [7:2] dir_q;
  logic [7:0] sel_q;
  logic       pu_q;
  logic [7:2] gp_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      dir_q <= '0;
      sel_q <= '0;
      pu_q  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        2'd0: dat_q <= wdata;
        2'd1: dir_q <= wdata[7:2];
        2'd2: sel_q <= wdata;
        default: if (!periph_mode) pu_q <= wdata[0];
      endcase
    end
  end

  assign gp_out = dir_q & ~sel_q[7:2];

  assign pad_oe  = {(sel_q[7:2] & fn_oe[7:2]) | gp_out, 2'b00};
  assign pad_out = {(sel_q[7:2] & fn_out[7:2]) | (~sel_q[7:2] & dat_q[7:2]), 2'b00};
  assign pad_pu  = pu_q ? PU_MASK : 8'h00;

  assign nmi_n = sel_q[0] ? pad_in[0] : 1'b1;
  assign irq_n = sel_q[1] ? pad_in[1] : 1'b1;

  always_comb begin
    case (addr)
      2'd0:    rdata = {(gp_out & dat_q[7:2]) | (~gp_out & pad_in[7:2]), pad_in[1:0]};
      2'd1:    rdata = {dir_q, 2'b00};
      2'd2:    rdata = sel_q;
      default: rdata = {7'd0, pu_q & ~periph_mode};
    endcase
  end

  // R4
  in_only_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[1:0] == 2'b00 && pad_out[1:0] == 2'b00);

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !sel_q[7]) |=> pad_oe[7] == $past(wdata[7]));

  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q[1] |-> irq_n) and (!sel_q[0] |-> nmi_n));

  // R7
  pu_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pad_pu) == 0 || $countones(pad_pu) == 5);

  // R8
  pu_periph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_mode && wr_en && addr == 2'd3) |=> $stable(pad_pu));

endmodule

// File: tb/ctl_port_test.sv
module ctl_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, fn_out = '0, fn_oe = '0, pad_in = '0;
  logic [7:0] rdata, pad_out, pad_oe, pad_pu;
  logic irq_n, nmi_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_port uut (.clk(clk), .rst_n(rst_n), .periph_mode(periph_mode), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .fn_out(fn_out), .fn_oe(fn_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq_n(irq_n), .nmi_n(nmi_n));

  // {sel, dir, dat, fn_out, fn_oe, pad_in, exp_oe, exp_out, exp_rd}
  localparam logic [71:0] VEC [6] = '{
    {8'h00, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hFC, 8'hA4, 8'hA4},
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h3C, 8'h00, 8'hFC, 8'h3C},
    {8'hF0, 8'hFF, 8'h0F, 8'hAA, 8'h50, 8'h81, 8'h5C, 8'hAC, 8'h8D},
    {8'hFF, 8'hFF, 8'h00, 8'h3C, 8'hC3, 8'h5A, 8'hC0, 8'h3C, 8'h5A},
    {8'h0C, 8'hF0, 8'h55, 8'hFF, 8'h0C, 8'hE7, 8'hFC, 8'h5C, 8'h57},
    {8'h03, 8'h03, 8'h03, 8'h00, 8'h03, 8'h02, 8'h00, 8'h00, 8'h02}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pu", pad_pu, 8'h00);
    check("R1 int", {6'd0, irq_n, nmi_n}, 8'h03);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, r); check("R1 dir", r, 8'h00);
    rd(2'd2, r); check("R1 sel", r, 8'h00);
    rd(2'd3, r); check("R1 pu reg", r, 8'h00);

    // R2 R3 R6 R9 vector table
    for (int i = 0; i < 6; i++) begin
      wr(2'd2, VEC[i][71:64]);
      wr(2'd1, VEC[i][63:56]);
      wr(2'd0, VEC[i][55:48]);
      fn_out = VEC[i][47:40]; fn_oe = VEC[i][39:32]; pad_in = VEC[i][31:24];
      rd(2'd0, r);
      check("R2/R3 oe", pad_oe, VEC[i][23:16]);
      check("R2/R3 out", pad_out, VEC[i][15:8]);
      check("R6 read", r, VEC[i][7:0]);
    end

    // R4 low direction bits
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, r); check("R4 dir readback", r, 8'hFC);
    check("R4 low oe", {6'd0, pad_oe[1:0]}, 8'h00);

    // R5 with R6 in the same cycle
    wr(2'd2, 8'h03);
    pad_in = 8'h01;
    rd(2'd0, r);
    check("R5 int", {6'd0, irq_n, nmi_n}, 8'h01);
    check("R6 low read", {6'd0, r[1:0]}, 8'h01);
    pad_in = 8'h02;
    rd(2'd0, r);
    check("R5 int", {6'd0, irq_n, nmi_n}, 8'h02);
    check("R6 low read", {6'd0, r[1:0]}, 8'h02);
    wr(2'd2, 8'h00);
    pad_in = 8'h00;
    rd(2'd0, r);
    check("R5 idle", {6'd0, irq_n, nmi_n}, 8'h03);
    check("R6 low read idle", {6'd0, r[1:0]}, 8'h00);

    // R7 pull-ups
    wr(2'd3, 8'h01);
    check("R7 pu on", pad_pu, 8'h8F);
    rd(2'd3, r); check("R7 pu reg", r, 8'h01);

    // R8 peripheral mode
    periph_mode = 1'b1;
    rd(2'd3, r); check("R8 read hidden", r, 8'h00);
    wr(2'd3, 8'h00);
    check("R8 write ignored", pad_pu, 8'h8F);
    periph_mode = 1'b0;
    rd(2'd3, r); check("R8 held", r, 8'h01);
    wr(2'd3, 8'h00);
    check("R7 pu off", pad_pu, 8'h00);
    periph_mode = 1'b1;
    wr(2'd3, 8'h01);
    check("R8 set ignored", pad_pu, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule